// File: doc/BRIEF.md
# Two-Floor Lift Controller

This block is the state machine for a lift car that serves two landings. It watches two landing call buttons, two car buttons, a door-hold button and a pulse from the landing sensor. From these it decides whether the door is open or shut, whether the car is travelling, and which way it is heading. The three control outputs are the state register itself, so no output decoding sits between the flops and the pins. A 7-segment code shows the landing the car last reached.

Every button press is stored in a sticky flag. A press that is seen on one clock edge is kept until the matching request has been served, so a short tap is not lost while the car is busy. The door stays open for a dwell time set by a parameter, and pressing the hold button restarts that time. When the dwell runs out with no request for the other landing, the door shuts and the car stays parked. A synchronous active-high reset parks the car at the lower landing with the door open.

Top module: `lift2_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is {door_shut,moving,heading_down}=000, all request flags are cleared, and `seg7` is 7'h06.
- R2: The state codes are {door_shut,moving,heading_down}: lower open 000, lower shut 100, rising 110, upper open 001, upper shut 101, falling 111. The codes 010 and 011 never occur.
- R3: In state 000, a pending `call_hi` or `car_hi` moves the state to 110 at the next edge.
- R4: When an open state (000 or 001) is entered, it lasts exactly DWELL_CYCLES cycles if nothing is pending, and then goes to its shut state (100 or 001→101).
- R5: In an open state, `hold_btn` reloads the dwell time, also in the cycle where the time runs out. A request for the other landing wins over both the hold and the timeout.
- R6: In state 100, `hold_btn` or `call_lo` gives 000, and this wins over `call_hi`/`car_hi`, which otherwise give 110. In state 101, `hold_btn` or `call_hi` gives 001, and this wins over `call_lo`/`car_lo`, which otherwise give 111. `car_lo` has no effect in 100, and `car_hi` has no effect in 101.
- R7: In 110 and 111, buttons do not change the state. `at_floor` moves 110 to 001 and 111 to 000. In all other states `at_floor` is ignored.
- R8: A press held across one clock edge is stored and acted on later. Lower requests are cleared whenever the next state is 000. Upper requests are cleared whenever the next state is 001. The hold flag is cleared whenever the next state is an open state.
- R9: `seg7` uses active-high gfedcba coding. It shows 7'h06 for the lower landing and 7'h5B for the upper landing, and it changes only on the edge where `at_floor` ends a trip.
- R10: In state 001, a pending `call_lo` or `car_lo` moves the state to 111 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_lo | input | 1 | Lower landing call button |
| call_hi | input | 1 | Upper landing call button |
| car_lo | input | 1 | Car button for the lower landing |
| car_hi | input | 1 | Car button for the upper landing |
| hold_btn | input | 1 | Door-hold button |
| at_floor | input | 1 | Landing sensor pulse |
| door_shut | output | 1 | 1 = door shut, 0 = door open |
| moving | output | 1 | 1 = car travelling |
| heading_down | output | 1 | 1 = direction down, 0 = up |
| seg7 | output | 7 | Landing number as a gfedcba segment code |

## Verification
The dwell expiry can fall in the same cycle as a hold press or a call for the other landing. The bench lets the dwell count down to its last cycle and then asserts `hold_btn`, `call_hi`, or both together in that cycle. A lone hold must keep the door open for a further full dwell, while a call must send the car upward whether or not the hold is also pressed. A second coincidence arises in the shut states, where a same-landing request and an other-landing request arrive together. The bench provokes it by sweeping all 32 button combinations in both shut states and checks that the same-landing request reopens the door.

// File: rtl/lift2_ctrl.sv
module lift2_ctrl #(
  parameter int DWELL_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       call_lo,
  input  logic       call_hi,
  input  logic       car_lo,
  input  logic       car_hi,
  input  logic       hold_btn,
  input  logic       at_floor,
  output logic       door_shut,
  output logic       moving,
  output logic       heading_down,
  output logic [6:0] seg7
);
  localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DWELL_CYCLES - 1);

  typedef enum logic [2:0] {
    LO_OPEN = 3'b000, LO_SHUT = 3'b100, RISE = 3'b110,
    HI_OPEN = 3'b001, HI_SHUT = 3'b101, FALL = 3'b111
  } st_t;

  st_t st, nx;
  logic [4:0] flg, btn, eff, clr;
  logic [CW-1:0] cnt;
  logic upper;

  // bit order: 0 call_lo, 1 call_hi, 2 car_lo, 3 car_hi, 4 hold
  assign btn = {hold_btn, car_hi, car_lo, call_hi, call_lo};
  assign eff = flg | btn;

  wire lo_req  = eff[0] | eff[2];
  wire hi_req  = eff[1] | eff[3];
  wire hold    = eff[4];
  wire expired = (cnt == '0);
  wire nx_lo   = (nx == LO_OPEN);
  wire nx_hi   = (nx == HI_OPEN);
  wire in_open = (st == LO_OPEN) || (st == HI_OPEN);

  always_comb begin
    nx = st;
    case (st)
      LO_OPEN: if (hi_req) nx = RISE;
               else if (expired && !hold) nx = LO_SHUT;
      HI_OPEN: if (lo_req) nx = FALL;
               else if (expired && !hold) nx = HI_SHUT;
      LO_SHUT: if (hold || eff[0]) nx = LO_OPEN;
               else if (hi_req) nx = RISE;
      HI_SHUT: if (hold || eff[1]) nx = HI_OPEN;
               else if (lo_req) nx = FALL;
      RISE:    if (at_floor) nx = HI_OPEN;
      FALL:    if (at_floor) nx = LO_OPEN;
      default: nx = LO_OPEN;
    endcase
  end

  assign clr = {nx_lo | nx_hi, nx_hi, nx_lo, nx_hi, nx_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LO_OPEN;
      flg   <= '0;
      cnt   <= RELOAD;
      upper <= 1'b0;
    end else begin
      st  <= nx;
      flg <= eff & ~clr;
      if ((nx_lo || nx_hi) && (nx != st || hold)) cnt <= RELOAD;
      else if (in_open && !expired) cnt <= cnt - 1'b1;
      if (at_floor && st == RISE) upper <= 1'b1;
      if (at_floor && st == FALL) upper <= 1'b0;
    end
  end

  assign {door_shut, moving, heading_down} = st;
  assign seg7 = upper ? 7'h5B : 7'h06;
endmodule

// File: rtl/lift2_chk.sv
module lift2_chk (
  input logic       clk,
  input logic       rst,
  input logic       call_lo,
  input logic       call_hi,
  input logic       car_hi,
  input logic       hold_btn,
  input logic       at_floor,
  input logic       door_shut,
  input logic       moving,
  input logic       heading_down,
  input logic [6:0] seg7
);
  wire [2:0] s = {door_shut, moving, heading_down};

  p_reset_r1: assert property (@(posedge clk) rst |=> (s == 3'b000 && seg7 == 7'h06));
  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst) !(!door_shut && moving));
  p_lo_leave_r3: assert property (@(posedge clk) disable iff (rst)
    (s == 3'b000 && (call_hi || car_hi)) |=> s == 3'b110);
  p_shut_prio_r6: assert property (@(posedge clk) disable iff (rst)
    (s == 3'b100 && (hold_btn || call_lo)) |=> s == 3'b000);
  p_travel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (moving && !at_floor) |=> s == $past(s));
  p_rise_arrive_r7: assert property (@(posedge clk) disable iff (rst)
    (s == 3'b110 && at_floor) |=> (s == 3'b001 && seg7 == 7'h5B));
  p_seg_steady_r9: assert property (@(posedge clk) disable iff (rst)
    !(moving && at_floor) |=> $stable(seg7));
endmodule

bind lift2_ctrl lift2_chk u_lift2_chk (
  .clk(clk), .rst(rst), .call_lo(call_lo), .call_hi(call_hi), .car_hi(car_hi),
  .hold_btn(hold_btn), .at_floor(at_floor), .door_shut(door_shut),
  .moving(moving), .heading_down(heading_down), .seg7(seg7)
);

// File: tb/test_lift2_ctrl.sv
module test_lift2_ctrl;
  localparam int D = 4;
  logic clk = 0, rst = 1;
  logic call_lo = 0, call_hi = 0, car_lo = 0, car_hi = 0, hold_btn = 0, at_floor = 0;
  logic door_shut, moving, heading_down;
  logic [6:0] seg7;
  int checks = 0, errors = 0;

  lift2_ctrl #(.DWELL_CYCLES(D)) i_lift2_ctrl (
    .clk(clk), .rst(rst), .call_lo(call_lo), .call_hi(call_hi), .car_lo(car_lo),
    .car_hi(car_hi), .hold_btn(hold_btn), .at_floor(at_floor), .door_shut(door_shut),
    .moving(moving), .heading_down(heading_down), .seg7(seg7)
  );

  always #10 clk = ~clk;

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] st();
    return {4'b0, door_shut, moving, heading_down};
  endfunction

  task automatic btns(input logic [4:0] k);
    {hold_btn, car_hi, car_lo, call_hi, call_lo} = k;
  endtask

  task automatic do_reset;
    rst = 1; btns(5'b0); at_floor = 0;
    tick; tick;
    rst = 0;
  endtask

  task automatic to_upper_shut;
    do_reset;
    repeat (D) tick;
    call_hi = 1; tick; call_hi = 0;
    at_floor = 1; tick; at_floor = 0;
    repeat (D) tick;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset;
    chk("R1 state", st(), 7'h00);
    chk("R1 seg", seg7, 7'h06);

    // R4 dwell at lower landing
    for (int i = 0; i < D - 1; i++) begin tick; chk("R4 open", st(), 7'h00); end
    tick; chk("R4 shut", st(), 7'h04);

    // R6 sweep in lower shut state
    for (int k = 0; k < 32; k++) begin
      logic [6:0] e;
      do_reset; repeat (D) tick;
      btns(k[4:0]); tick; btns(5'b0);
      e = (k[4] || k[0]) ? 7'h00 : (k[1] || k[3]) ? 7'h06 : 7'h04;
      chk("R6 lower shut", st(), e);
    end

    // R6 sweep in upper shut state, R2 codes on the way
    for (int k = 0; k < 32; k++) begin
      logic [6:0] e;
      to_upper_shut;
      chk("R2 upper shut code", st(), 7'h05);
      btns(k[4:0]); tick; btns(5'b0);
      e = (k[4] || k[1]) ? 7'h01 : (k[0] || k[2]) ? 7'h07 : 7'h05;
      chk("R6 upper shut", st(), e);
    end

    // R5 hold reloads dwell
    do_reset; tick; tick;
    hold_btn = 1; tick; hold_btn = 0;
    for (int i = 0; i < D - 1; i++) begin tick; chk("R5 reload open", st(), 7'h00); end
    tick; chk("R5 reload shut", st(), 7'h04);

    // R5 hold in the expiry cycle
    do_reset; repeat (D - 1) tick;
    hold_btn = 1; tick; hold_btn = 0;
    chk("R5 hold at expiry", st(), 7'h00);
    repeat (D - 1) tick;
    chk("R5 extended open", st(), 7'h00);
    tick; chk("R5 extended shut", st(), 7'h04);

    // R5 call beats hold and expiry
    do_reset; repeat (D - 1) tick;
    call_hi = 1; hold_btn = 1; tick; btns(5'b0);
    chk("R5 call wins", st(), 7'h06);

    // R3 car button
    do_reset; car_hi = 1; tick; car_hi = 0;
    chk("R3 car_hi", st(), 7'h06);

    // R7 buttons ignored while rising, R8 sticky, R9 display
    btns(5'b10111);
    for (int i = 0; i < 3; i++) begin
      tick; chk("R7 rise holds", st(), 7'h06); chk("R9 seg rising", seg7, 7'h06);
    end
    btns(5'b0);
    at_floor = 1; tick; at_floor = 0;
    chk("R7 rise arrive", st(), 7'h01);
    chk("R9 seg upper", seg7, 7'h5B);
    tick; chk("R8 stored call acts", st(), 7'h07);
    tick; chk("R7 fall holds", st(), 7'h07);
    at_floor = 1; tick; at_floor = 0;
    chk("R7 fall arrive", st(), 7'h00);
    chk("R9 seg lower", seg7, 7'h06);

    // R8 served request is cleared
    do_reset; call_lo = 1; tick; call_lo = 0;
    call_hi = 1; tick; call_hi = 0;
    at_floor = 1; tick; at_floor = 0;
    tick; chk("R8 cleared lower call", st(), 7'h01);

    // R8 one-cycle press while moving
    do_reset; call_hi = 1; tick; call_hi = 0;
    car_lo = 1; tick; car_lo = 0;
    chk("R8 pressed while rising", st(), 7'h06);
    at_floor = 1; tick; at_floor = 0;
    tick; chk("R8 stored car_lo", st(), 7'h07);

    // R10 upper open to falling
    do_reset; call_hi = 1; tick; call_hi = 0;
    at_floor = 1; tick; at_floor = 0;
    call_lo = 1; tick; call_lo = 0;
    chk("R10 call_lo", st(), 7'h07);

    // R7 at_floor ignored when parked
    do_reset; at_floor = 1; tick; at_floor = 0;
    chk("R7 arrive ignored", st(), 7'h00);
    chk("R9 seg unchanged", seg7, 7'h06);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule